// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Stop-Bit Checking

This block receives asynchronous serial frames on a single line for a microcontroller-style serial port. The line is resynchronised to the system clock and sampled sixteen times per bit. Each bit is decided by a majority vote near its centre. The result is a received byte, a receive-done flag and a sticky framing-error flag. The block handles two frame lengths. The 10-bit frame has a start bit, eight data bits sent least significant bit first, and one stop bit. The 11-bit frame adds a ninth data bit before the stop bit.

An 8-bit control register holds the mode, the receive enable, the received ninth bit and the receive-done flag. Its top bit has two pieces of storage behind it. An external select input picks which one is visible. With select low, the top bit is the upper mode bit. With select high, it is the framing-error flag. The select input also turns stop-bit checking on. When checking is on, the receive-done flag is raised at the stop bit instead of at the last data bit. A baud divider produces one sample enable every `SAMPLE_DIV` clocks, so one bit lasts `16*SAMPLE_DIV` clocks.

Top module: `uart_rx_fchk`

## Requirements
- R1: After a synchronous reset, the register reads 0x00, and `ri`, `fe` and `rx_byte` are all 0.
- R2: Register bit 7 is the upper mode bit and bit 6 is the lower mode bit. When both are zero, the receiver ignores the line. With mode bits 0,1, a 10-bit frame (start, eight data bits LSB first, stop) loads `rx_byte` and raises `ri`.
- R3: With mode bits 1,0 or 1,1, the receiver takes 11-bit frames. The ninth data bit is stored into register bit 4 when the frame is accepted.
- R4: With `err_chk_sel` low, `ri` rises during the last data bit, before the middle of the stop bit. With `err_chk_sel` high, `ri` rises only after the stop bit has been sampled.
- R5: With `err_chk_sel` high, a stop bit sampled as 0 sets `fe`. With `err_chk_sel` low, a bad stop bit never sets `fe`.
- R6: `fe` is sticky. A later frame with a good stop bit leaves it set. Only a write of 0 to bit 7 while `err_chk_sel` is high, or a reset, clears it.
- R7: Writes to bit 7 go to `fe` when `err_chk_sel` is 1 and to the upper mode bit when it is 0. The storage that is not selected keeps its value. Reads of bit 7 return the selected storage.
- R8: A frame is dropped if register bit 5 (receive enable) is 0 or if `ri` (register bit 0) is already 1. A dropped frame changes neither `rx_byte` nor bit 4, and `ri` keeps its value.
- R9: A falling edge on the line whose level is high again at the mid-bit sample is a false start. It returns the receiver to idle with no frame. A later valid frame is received normally.
- R10: A line disturbance no longer than one sample period inside a data bit does not change the decided bit, because of the 2-of-3 vote on samples 7, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| err_chk_sel | input | 1 | Selects the flag behind bit 7 and enables stop-bit checking |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| rx_byte | output | 8 | Last accepted data byte |
| ri | output | 1 | Receive-done flag (register bit 0) |
| fe | output | 1 | Sticky framing-error flag |

## Verification
Assertions check several rules on every cycle:
- `fe` never falls unless a selected clearing write occurs.
- A write with the error flag selected leaves the mode bit unchanged, and `fe` stays low while checking is off.
- `ri` cannot rise with reception disabled, and `rx_byte` holds while `ri` is set.
- The receiver stays idle in the disabled mode, a false start returns it to idle, and every accept request comes from the stop bit exactly when checking was on.

Only the bench's scenarios can show the following:
- The actual cycle at which `ri` rises relative to the stop bit.
- The bit order of received data and the ninth-bit capture.
- Vote tolerance to a glitch.
- That a good frame after a bad one keeps `fe` set.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;

  // Event bundle from the frame engine to the register block
  typedef struct packed {
    logic take;      // request to accept the frame (raise ri)
    logic stop_chk;  // stop bit has just been decided
    logic stop_bit;  // decided stop bit value
  } rx_evt_t;

  localparam int REG_W       = 8;
  localparam int POS_MODE_HI = 7;
  localparam int POS_MODE_LO = 6;
  localparam int POS_ENABLE  = 5;
  localparam int POS_NINTH   = 4;
  localparam int POS_DONE    = 0;

endpackage

// File: rtl/srx_tick.sv
module srx_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else if (div_q == LAST) begin
      div_q <= '0;
      tick  <= 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/srx_frame.sv
module srx_frame import srx_pkg::*; #(
  parameter int OSR  = 16,
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxd_in,
  input  logic          allow,
  input  logic          long_frame,
  input  logic          chk_on,
  input  logic          tick,
  output logic          run,
  output rx_evt_t       evt,
  output logic [DW-1:0] shift,
  output logic          ninth
);

  localparam int SW = $clog2(OSR);
  localparam int BW = $clog2(DW + 1);
  localparam logic [SW-1:0] S_A   = SW'(OSR / 2 - 1);
  localparam logic [SW-1:0] S_MID = SW'(OSR / 2);
  localparam logic [SW-1:0] S_B   = SW'(OSR / 2 + 1);
  localparam logic [SW-1:0] S_END = SW'(OSR - 1);
  localparam logic [BW-1:0] B_SHORT = BW'(DW - 1);
  localparam logic [BW-1:0] B_LONG  = BW'(DW);

  logic [SYNC-1:0] sync_q;
  logic            rs;
  logic            prev_q;
  rx_state_t       st;
  logic [SW-1:0]   cnt;
  logic [BW-1:0]   bidx;
  logic            va_q, vm_q;
  logic            fall, at_a, at_mid, at_b, at_end, vote;
  logic [BW-1:0]   last_idx;
  rx_evt_t         evt_d;

  // Line resynchroniser, depth chosen by parameter
  generate
    for (genvar g = 0; g < SYNC; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= rxd_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rs       = sync_q[SYNC-1];
  assign fall     = prev_q & ~rs;
  assign at_a     = tick && (cnt == S_A);
  assign at_mid   = tick && (cnt == S_MID);
  assign at_b     = tick && (cnt == S_B);
  assign at_end   = tick && (cnt == S_END);
  assign vote     = (va_q & vm_q) | (va_q & rs) | (vm_q & rs);
  assign last_idx = long_frame ? B_LONG : B_SHORT;
  assign run      = (st != ST_IDLE);

  always_comb begin
    evt_d          = '0;
    evt_d.stop_bit = vote;
    if (st == ST_DATA && at_b && bidx == last_idx && !chk_on) evt_d.take = 1'b1;
    if (st == ST_STOP && at_b) begin
      evt_d.stop_chk = 1'b1;
      evt_d.take     = chk_on;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      st     <= ST_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      va_q   <= 1'b1;
      vm_q   <= 1'b1;
      shift  <= '0;
      ninth  <= 1'b0;
      evt    <= '0;
    end else begin
      prev_q <= rs;
      evt    <= evt_d;
      if (st != ST_IDLE && tick) begin
        cnt <= (cnt == S_END) ? '0 : cnt + 1'b1;
        if (at_a)   va_q <= rs;
        if (at_mid) vm_q <= rs;
      end
      case (st)
        ST_IDLE: begin
          cnt  <= '0;
          bidx <= '0;
          if (allow && fall) st <= ST_START;
        end
        ST_START: begin
          if (at_mid && rs)  st <= ST_IDLE;
          else if (at_end) begin
            st   <= ST_DATA;
            bidx <= '0;
          end
        end
        ST_DATA: begin
          if (at_b) begin
            if (bidx < B_LONG) shift <= {vote, shift[DW-1:1]};
            else               ninth <= vote;
          end
          if (at_end) begin
            if (bidx == last_idx) st <= ST_STOP;
            else                  bidx <= bidx + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_b) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: no frame starts while reception is not allowed
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !allow) |=> (st == ST_IDLE));

  // R9: a high line at the mid-bit sample of the start bit aborts the frame
  p_false_start_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && at_mid && rs) |=> (st == ST_IDLE));

  // R4: accept requests come from the stop bit exactly when checking was on
  p_take_point_r4: assert property (@(posedge clk) disable iff (rst)
    evt.take |-> (evt.stop_chk == $past(chk_on)));

endmodule

// File: rtl/srx_regs.sv
module srx_regs import srx_pkg::*; #(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             fe_sel,
  input  rx_evt_t          evt,
  input  logic [DW-1:0]    rx_shift,
  input  logic             rx_ninth,
  output logic [REG_W-1:0] rdata,
  output logic [DW-1:0]    rx_byte,
  output logic             ri,
  output logic             fe,
  output logic             allow,
  output logic             long_frame
);

  logic sm0_q, sm1_q, ren_q, rb8_q, ri_q, fe_q;
  logic accept;
  logic unused_wbits;

  assign unused_wbits = ^wdata[POS_NINTH:1];
  assign accept       = evt.take && ren_q && !ri_q;
  assign allow        = ren_q && (sm0_q || sm1_q);
  assign long_frame   = sm0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sm0_q   <= 1'b0;
      sm1_q   <= 1'b0;
      ren_q   <= 1'b0;
      rb8_q   <= 1'b0;
      ri_q    <= 1'b0;
      fe_q    <= 1'b0;
      rx_byte <= '0;
    end else begin
      if (we) begin
        sm1_q <= wdata[POS_MODE_LO];
        ren_q <= wdata[POS_ENABLE];
        if (!fe_sel) sm0_q <= wdata[POS_MODE_HI];
      end
      if (evt.stop_chk && fe_sel && !evt.stop_bit) fe_q <= 1'b1;
      else if (we && fe_sel)                       fe_q <= wdata[POS_MODE_HI];
      if (accept) begin
        ri_q    <= 1'b1;
        rx_byte <= rx_shift;
        if (sm0_q) rb8_q <= rx_ninth;
      end else if (we) begin
        ri_q <= wdata[POS_DONE];
      end
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[POS_MODE_HI] = fe_sel ? fe_q : sm0_q;
    rdata[POS_MODE_LO] = sm1_q;
    rdata[POS_ENABLE]  = ren_q;
    rdata[POS_NINTH]   = rb8_q;
    rdata[POS_DONE]    = ri_q;
  end

  assign ri = ri_q;
  assign fe = fe_q;

  // R6: the error flag only falls through a selected clearing write
  p_fe_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (fe_q && !(we && fe_sel && !wdata[POS_MODE_HI])) |=> fe_q);

  // R5: with checking off nothing can raise the error flag
  p_fe_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!fe_q && !fe_sel) |=> !fe_q);

  // R7: a write while the flag is selected leaves the mode bit alone
  p_mode_guard_r7: assert property (@(posedge clk) disable iff (rst)
    !(we && !fe_sel) |=> $stable(sm0_q));

  // R8: with reception disabled, ri cannot rise except by a write
  p_no_take_r8: assert property (@(posedge clk) disable iff (rst)
    (!ri_q && !ren_q && !(we && wdata[POS_DONE])) |=> !ri_q);

  // R8: the byte holds while ri is pending
  p_byte_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ri_q |=> $stable(rx_byte));

endmodule

// File: rtl/uart_rx_fchk.sv
module uart_rx_fchk import srx_pkg::*; #(
  parameter int SAMPLE_DIV = 4,
  parameter int OSR        = 16,
  parameter int DW         = 8,
  parameter int SYNC       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd,
  input  logic             err_chk_sel,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic [DW-1:0]    rx_byte,
  output logic             ri,
  output logic             fe
);

  logic          run, tick, allow, long_frame, ninth;
  rx_evt_t       evt;
  logic [DW-1:0] shift;

  srx_tick #(.DIV(SAMPLE_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  srx_frame #(.OSR(OSR), .DW(DW), .SYNC(SYNC)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .rxd_in     (rxd),
    .allow      (allow),
    .long_frame (long_frame),
    .chk_on     (err_chk_sel),
    .tick       (tick),
    .run        (run),
    .evt        (evt),
    .shift      (shift),
    .ninth      (ninth)
  );

  srx_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .fe_sel     (err_chk_sel),
    .evt        (evt),
    .rx_shift   (shift),
    .rx_ninth   (ninth),
    .rdata      (cfg_rdata),
    .rx_byte    (rx_byte),
    .ri         (ri),
    .fe         (fe),
    .allow      (allow),
    .long_frame (long_frame)
  );

endmodule

// File: tb/uart_rx_fchk_tb.sv
`timescale 1ns/1ps
module uart_rx_fchk_tb;

  localparam int BIT   = 64;   // 16 samples x 4 clocks
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       sel = 1'b0;
  logic       we  = 1'b0;
  logic [7:0] wd  = 8'h00;
  logic [7:0] rd, byte_o;
  logic       ri, fe;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       early;

  always #5 clk = ~clk;

  uart_rx_fchk u_dut (
    .clk(clk), .rst(rst), .rxd(rxd), .err_chk_sel(sel),
    .cfg_we(we), .cfg_wdata(wd), .cfg_rdata(rd),
    .rx_byte(byte_o), .ri(ri), .fe(fe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    we = 1'b1; wd = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic send_bit(input logic v, input bit glitch);
    rxd = v;
    if (glitch) begin
      wait_clk(36); rxd = ~v; wait_clk(3); rxd = v; wait_clk(BIT - 39);
    end else wait_clk(BIT);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic nine, input bit long_f,
                            input logic stop_v, input bit glitch, output logic ri_q);
    @(negedge clk);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i], glitch);
    if (long_f) send_bit(nine, 1'b0);
    rxd = stop_v;
    wait_clk(16);
    ri_q = ri;
    wait_clk(BIT - 16);
    rxd = 1'b1;
    wait_clk(BIT);
  endtask

  task automatic t_reset;
    check("R1 rdata", rd, 8'h00);
    check("R1 ri", {7'd0, ri}, 8'h00);
    check("R1 fe", {7'd0, fe}, 8'h00);
    check("R1 rx_byte", byte_o, 8'h00);
  endtask

  task automatic t_alias;
    sel = 1'b0; wr(8'hE0);
    check("R7 mode bit written", rd, 8'hE0);
    sel = 1'b1; wait_clk(1);
    check("R7 flag view", rd, 8'h60);
    wr(8'hE0);
    check("R7 flag written", rd, 8'hE0);
    check("R7 fe port", {7'd0, fe}, 8'h01);
    sel = 1'b0; wait_clk(1);
    check("R7 mode kept", rd, 8'hE0);
    wr(8'h60);
    check("R7 mode cleared", rd, 8'h60);
    sel = 1'b1; wait_clk(1);
    check("R7 flag kept", rd, 8'hE0);
    wr(8'h60);
    check("R7 flag cleared", rd, 8'h60);
    sel = 1'b0; wait_clk(1);
  endtask

  task automatic t_mode1;
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, early);
    check("R4 ri before stop mid (check off)", {7'd0, early}, 8'h01);
    check("R2 byte A5", byte_o, 8'hA5);
    check("R2 ri set", {7'd0, ri}, 8'h01);
    wr(8'h60);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, early);
    check("R2 byte 3C", byte_o, 8'h3C);
    wr(8'h60);
  endtask

  task automatic t_ri_on;
    sel = 1'b1;
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, early);
    check("R4 ri low before stop sample (check on)", {7'd0, early}, 8'h00);
    check("R4 ri after stop", {7'd0, ri}, 8'h01);
    check("R5 good stop no fe", {7'd0, fe}, 8'h00);
    check("R4 byte 5A", byte_o, 8'h5A);
    wr(8'h60);
  endtask

  task automatic t_fe_sticky;
    sel = 1'b1;
    send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, early);
    check("R5 bad stop sets fe", {7'd0, fe}, 8'h01);
    check("R5 byte 11", byte_o, 8'h11);
    wr(8'hE0);
    send_frame(8'h22, 1'b0, 1'b0, 1'b1, 1'b0, early);
    check("R6 fe stays after good frame", {7'd0, fe}, 8'h01);
    check("R6 byte 22", byte_o, 8'h22);
    wr(8'h60);
    check("R6 fe cleared by write", {7'd0, fe}, 8'h00);
    sel = 1'b0;
    send_frame(8'h33, 1'b0, 1'b0, 1'b0, 1'b0, early);
    check("R5 check off no fe", {7'd0, fe}, 8'h00);
    check("R5 byte 33", byte_o, 8'h33);
    wr(8'h60);
  endtask

  task automatic t_mode23;
    sel = 1'b0;
    wr(8'hA0);
    send_frame(8'h96, 1'b1, 1'b1, 1'b1, 1'b0, early);
    check("R4 ri at ninth bit (check off)", {7'd0, early}, 8'h01);
    check("R3 byte 96", byte_o, 8'h96);
    check("R3 ninth=1 in reg", rd, 8'hB1);
    wr(8'hE0);
    check("R3 ninth held", rd, 8'hF0);
    send_frame(8'h0F, 1'b0, 1'b1, 1'b1, 1'b0, early);
    check("R3 byte 0F", byte_o, 8'h0F);
    check("R3 ninth=0 in reg", rd, 8'hE1);
  endtask

  task automatic t_drop;
    send_frame(8'h77, 1'b1, 1'b1, 1'b1, 1'b0, early);
    check("R8 byte kept when ri set", byte_o, 8'h0F);
    check("R8 reg kept when ri set", rd, 8'hE1);
    wr(8'hC0);
    send_frame(8'h55, 1'b0, 1'b1, 1'b1, 1'b0, early);
    check("R8 ri stays low with enable off", {7'd0, ri}, 8'h00);
    check("R8 byte kept with enable off", byte_o, 8'h0F);
    wr(8'h20);
    send_frame(8'h44, 1'b0, 1'b0, 1'b1, 1'b0, early);
    check("R2 mode 00 ignores line", {7'd0, ri}, 8'h00);
    check("R2 mode 00 byte kept", byte_o, 8'h0F);
  endtask

  task automatic t_false_start;
    wr(8'h60);
    @(negedge clk);
    rxd = 1'b0; wait_clk(20); rxd = 1'b1;
    wait_clk(2 * BIT);
    check("R9 false start no ri", {7'd0, ri}, 8'h00);
    check("R9 false start byte kept", byte_o, 8'h0F);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, early);
    check("R9 recovery byte C3", byte_o, 8'hC3);
    wr(8'h60);
  endtask

  task automatic t_glitch;
    send_frame(8'h81, 1'b0, 1'b0, 1'b1, 1'b1, early);
    check("R10 glitch tolerated", byte_o, 8'h81);
    check("R10 ri set", {7'd0, ri}, 8'h01);
    wr(8'h60);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_alias();
    t_mode1();
    t_ri_on();
    t_fe_sticky();
    t_mode23();
    t_drop();
    t_false_start();
    t_glitch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule